// File: doc/BRIEF.md
# Bit-Typed Host Register Store

This block is the backing store for a host-controller register map: a 32-bit wide memory addressed by a dword index. The lower half of the address space carries an access type for every single bit, so a software write can set, clear or overwrite individual flags inside one register while leaving read-only bits intact. The upper half is plain read/write storage used for the command-list and received-frame areas.

Software reaches the store through a bus port with a dword address, a write strobe, write data and registered read data. A write to the typed half is a two-cycle read-modify-write. The first cycle captures the current word and its type bits, and the second cycle writes the merged result. While that write is pending the block raises a busy flag and drops any further bus write. A second, internal port lets hardware update status fields or deposit received frame words directly. That port writes the whole dword and ignores the bit types.

A synchronous reset loads every dword from a computed default table. The per-bit types come from a computed type table with two bits per register bit.

Top module: `bitwise_typed_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every dword is reloaded with its default: dword 0x003 reads 0x00000001, dword 0x004 reads 0x00010301, all other dwords read 0, and `bus_busy` is 0.
- R2: `bus_rdata` shows the content of the dword at `bus_addr` as it stood at the previous clock edge (one cycle of read latency). It does not change before that edge.
- R3: Each typed bit has a 2-bit access code: 0 = read-only, 1 = plain write, 2 = write-one-clears, 3 = write-one-sets. A bus write leaves read-only bits unchanged.
- R4: A bus write copies the written value into plain-write bits.
- R5: A bus write clears a write-one-clears bit where the data bit is 1 and leaves it where the data bit is 0.
- R6: A bus write sets a write-one-sets bit where the data bit is 1 and leaves it where the data bit is 0.
- R7: A bus write to the typed half (`bus_addr[9]` = 0) is accepted when `bus_busy` is 0. `bus_busy` is then 1 for exactly the next cycle, and the merged value is stored at the edge that ends that cycle. A bus write presented while `bus_busy` is 1 is dropped.
- R8: A bus write to the upper half (`bus_addr[9]` = 1) stores all 32 bits at the same edge and does not raise `bus_busy`.
- R9: The internal port (`hw_we`) stores the full `hw_wdata` at `hw_addr` at the same edge, including into read-only bits.
- R10: If the internal port and a bus write (single-cycle, or the second cycle of a typed write) store to the same dword at the same edge, the internal data is kept.
- R11: The type map is as follows. Dword 0x001 is all plain-write. Dword 0x002 is all write-one-clears. Dword 0x046 has bits 7:0 plain-write, bits 15:8 write-one-sets, bits 23:16 write-one-clears and bits 31:24 read-only. Dword 0x04C has bits 26:16, 11:8, 1 and 0 write-one-clears and the other bits read-only. Dword 0x04D is all write-one-sets. Every other typed dword is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads defaults |
| bus_addr | input | 10 | Dword index for bus read and write |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| bus_busy | output | 1 | Typed write pending; bus writes are dropped |
| hw_we | input | 1 | Internal write strobe |
| hw_addr | input | 10 | Internal write dword index |
| hw_wdata | input | 32 | Internal write data, stored without type rules |

## Verification
The mixed dword that holds all four access codes is tried with every pairing of four previous values and four write values: all zeros, all ones, and two alternating patterns. The alternating patterns are offset so that a set rule, a clear rule, a plain copy and a hold produce different bytes, so a swap of any two codes shows up. The reset sweep reads back every dword and tells the two non-zero defaults apart from the zero fill. Write patterns derived from the address go to the upper half and to the error-flag, set-only, read-only and unmapped dwords, which separate single-cycle from two-cycle storage and typed from untyped behaviour. Timed collisions check that a write presented during the busy cycle is dropped and that the internal port wins on a shared address.

// File: rtl/tr_pkg.sv
// Package: tr_pkg
// Shared access-code type and the computed default and type tables for the
// bit-typed register store. Assumes a 32-bit word; map entries sit below
// dword 0x100, so any address width of 9 bits or more holds them.
package tr_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_RO   = 2'd0,
        ACC_RW   = 2'd1,
        ACC_CLR1 = 2'd2,
        ACC_SET1 = 2'd3
    } acc_t;

    // Reset value of a dword; everything not listed is zero
    function automatic logic [WORD_W-1:0] dflt_word(input int unsigned idx);
        case (idx)
            32'h003: dflt_word = 32'h0000_0001;
            32'h004: dflt_word = 32'h0001_0301;
            default: dflt_word = '0;
        endcase
    endfunction

    // Access codes of a typed dword, two bits per register bit (bit i at [2i+1:2i])
    function automatic logic [2*WORD_W-1:0] type_word(input int unsigned idx);
        logic [2*WORD_W-1:0] t;
        t = '0;
        for (int i = 0; i < WORD_W; i++) begin
            case (idx)
                32'h001: t[2*i +: 2] = ACC_RW;
                32'h002: t[2*i +: 2] = ACC_CLR1;
                32'h046: begin
                    if (i < 8)       t[2*i +: 2] = ACC_RW;
                    else if (i < 16) t[2*i +: 2] = ACC_SET1;
                    else if (i < 24) t[2*i +: 2] = ACC_CLR1;
                    else             t[2*i +: 2] = ACC_RO;
                end
                32'h04C: begin
                    if ((i >= 16 && i <= 26) || (i >= 8 && i <= 11) || i <= 1)
                        t[2*i +: 2] = ACC_CLR1;
                    else
                        t[2*i +: 2] = ACC_RO;
                end
                32'h04D: t[2*i +: 2] = ACC_SET1;
                default: t[2*i +: 2] = ACC_RO;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/tr_type_table.sv
// Module: tr_type_table
// Combinational lookup of the per-bit access codes for one typed dword.
// Assumes the caller passes only the offset inside the typed half.
module tr_type_table #(
    parameter int IDX_W  = 9,
    parameter int WORD_W = 32
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [2*WORD_W-1:0] types
);
    // Table content is computed, not stored
    always_comb begin
        types = tr_pkg::type_word(32'(idx));
    end
endmodule

// File: rtl/tr_bit_merge.sv
// Module: tr_bit_merge
// Applies the per-bit write rule to one dword: keep, copy, clear-on-one or
// set-on-one. Assumes types use the tr_pkg::acc_t encoding.
module tr_bit_merge #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_en,
    input  logic [WORD_W-1:0]   old_word,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic [2*WORD_W-1:0] types,
    output logic [WORD_W-1:0]   new_word
);
    import tr_pkg::*;

    logic [WORD_W-1:0] ro_mask;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] set_mask;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        acc_t code;
        assign code = acc_t'(types[2*b +: 2]);
        // Per-bit rule selection
        assign new_word[b] = (code == ACC_RW)   ? wr_word[b] :
                             (code == ACC_CLR1) ? (old_word[b] & ~wr_word[b]) :
                             (code == ACC_SET1) ? (old_word[b] |  wr_word[b]) :
                                                  old_word[b];
        assign ro_mask[b]  = (types[2*b +: 2] == 2'd0);
        assign clr_mask[b] = (types[2*b +: 2] == 2'd2);
        assign set_mask[b] = (types[2*b +: 2] == 2'd3);
    end

    // R3
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> (((new_word ^ old_word) & ro_mask) == '0));
    // R5
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> ((new_word & ~old_word & clr_mask) == '0));
    // R6
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> ((old_word & ~new_word & set_mask) == '0));
endmodule

// File: rtl/tr_store.sv
// Module: tr_store
// Flop-based dword storage with two write ports (bus-side and internal),
// a registered read port and a combinational peek port. Assumes the internal
// port has priority on a shared address; reset reloads the default table.
module tr_store #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_data,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [WORD_W-1:0] h_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Reset load and writes; internal port written last so it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= tr_pkg::dflt_word(i);
            end
        end else begin
            if (a_we) mem[a_addr] <= a_data;
            if (h_we) mem[h_addr] <= h_data;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end

    // Current-content peek for the read-modify-write first cycle
    always_comb begin
        peek_data = mem[peek_addr];
    end

    // R10
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && h_we && (a_addr == h_addr)) |=> (mem[$past(h_addr)] == $past(h_data)));
endmodule

// File: rtl/bitwise_typed_regfile.sv
// Module: bitwise_typed_regfile
// Register store whose lower half applies per-bit access rules through a
// two-cycle read-modify-write and whose upper half is single-cycle RAM.
// Assumes bus writes are dropped while bus_busy is high.
module bitwise_typed_regfile #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_busy,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [WORD_W-1:0] hw_wdata
);
    localparam int IDX_W = ADDR_W - 1;

    logic                pend_q;
    logic [ADDR_W-1:0]   pend_addr;
    logic [WORD_W-1:0]   pend_wdata;
    logic [WORD_W-1:0]   pend_old;
    logic [2*WORD_W-1:0] pend_types;

    logic [2*WORD_W-1:0] look_types;
    logic [WORD_W-1:0]   cur_word;
    logic [WORD_W-1:0]   merged;
    logic                take;
    logic                typed_sel;
    logic                a_we;
    logic [ADDR_W-1:0]   a_addr;
    logic [WORD_W-1:0]   a_data;

    assign typed_sel = ~bus_addr[ADDR_W-1];
    assign take      = bus_we & ~pend_q;
    assign bus_busy  = pend_q;

    tr_type_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) type_i (
        .idx   (bus_addr[IDX_W-1:0]),
        .types (look_types)
    );

    // First cycle of a typed write: capture old word (forwarding a same-cycle internal write) and types
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_addr  <= '0;
            pend_wdata <= '0;
            pend_old   <= '0;
            pend_types <= '0;
        end else begin
            pend_q <= take & typed_sel;
            if (take & typed_sel) begin
                pend_addr  <= bus_addr;
                pend_wdata <= bus_wdata;
                pend_old   <= (hw_we && hw_addr == bus_addr) ? hw_wdata : cur_word;
                pend_types <= look_types;
            end
        end
    end

    tr_bit_merge #(.WORD_W(WORD_W)) merge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (pend_q),
        .old_word (pend_old),
        .wr_word  (pend_wdata),
        .types    (pend_types),
        .new_word (merged)
    );

    // Bus-side store port: second typed cycle or a single-cycle upper write
    always_comb begin
        a_we   = pend_q | (take & ~typed_sel);
        a_addr = pend_q ? pend_addr : bus_addr;
        a_data = pend_q ? merged    : bus_wdata;
    end

    tr_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_we      (a_we),
        .a_addr    (a_addr),
        .a_data    (a_data),
        .h_we      (hw_we),
        .h_addr    (hw_addr),
        .h_data    (hw_wdata),
        .rd_addr   (bus_addr),
        .rd_data   (bus_rdata),
        .peek_addr (bus_addr),
        .peek_data (cur_word)
    );

    // R7
    typed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_busy && !bus_addr[ADDR_W-1]) |=> bus_busy);
    // R7
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> !bus_busy);
    // R8
    upper_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_busy && bus_addr[ADDR_W-1]) |=> !bus_busy);
endmodule

// File: tb/bitwise_typed_regfile_tb.sv
module bitwise_typed_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_busy;
    logic        hw_we = 1'b0;
    logic [9:0]  hw_addr = '0;
    logic [31:0] hw_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bitwise_typed_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_busy(bus_busy),
        .hw_we(hw_we), .hw_addr(hw_addr), .hw_wdata(hw_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        bus_addr = a;
        bus_we   = 1'b0;
        tick();
        v = bus_rdata;
    endtask

    task automatic hw_wr(input logic [9:0] a, input logic [31:0] d);
        hw_we = 1'b1; hw_addr = a; hw_wdata = d;
        tick();
        hw_we = 1'b0;
    endtask

    // Bus write; checks busy timing of R7 / R8
    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        if (!a[9]) begin
            chk("R7 busy after typed write", {31'b0, bus_busy}, 32'd1);
            tick();
            chk("R7 busy drops", {31'b0, bus_busy}, 32'd0);
        end else begin
            chk("R8 no busy on upper write", {31'b0, bus_busy}, 32'd0);
        end
    endtask

    function automatic logic [31:0] exp_mixed(input logic [31:0] o, input logic [31:0] w);
        return {o[31:24], o[23:16] & ~w[23:16], o[15:8] | w[15:8], w[7:0]};
    endfunction

    function automatic logic [31:0] upper_pat(input int a);
        return 32'(a) * 32'h9E37_79B1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [4];
        logic [31:0] exp;
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h3C3C_C3C3;

        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 busy low after reset", {31'b0, bus_busy}, 32'd0);

        // R1: full reset sweep
        for (int a = 0; a < 1024; a++) begin
            rd(10'(a), v);
            exp = (a == 3) ? 32'h1 : (a == 4) ? 32'h0001_0301 : 32'h0;
            chk("R1 reset default", v, exp);
        end

        // R2: read latency of one cycle
        bus_wr(10'h2A0, 32'hCAFE_0001);
        rd(10'h000, v);
        bus_addr = 10'h2A0;
        #3;
        chk("R2 rdata not yet updated", bus_rdata, 32'h0);
        @(posedge clk); #1;
        chk("R2 rdata after one edge", bus_rdata, 32'hCAFE_0001);

        // R3 R4 R5 R6 R11: mixed dword 0x046 swept over old x write patterns
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                hw_wr(10'h046, pats[i]);
                bus_wr(10'h046, pats[j]);
                rd(10'h046, v);
                chk("R3/R4/R5/R6 mixed dword merge", v, exp_mixed(pats[i], pats[j]));
            end
        end

        // R11 R5: error-flag dword 0x04C
        hw_wr(10'h04C, 32'hFFFF_FFFF);
        bus_wr(10'h04C, 32'hFFFF_FFFF);
        rd(10'h04C, v);
        chk("R5 error flags cleared, RO kept", v, 32'hF800_F0FC);
        bus_wr(10'h04C, 32'h0);
        rd(10'h04C, v);
        chk("R11 error dword zero write no effect", v, 32'hF800_F0FC);

        // R6: set-only dword 0x04D
        bus_wr(10'h04D, 32'h0000_00F0);
        bus_wr(10'h04D, 32'h0F00_0000);
        rd(10'h04D, v);
        chk("R6 set-only accumulates", v, 32'h0F00_00F0);
        bus_wr(10'h04D, 32'h0);
        rd(10'h04D, v);
        chk("R6 zero write leaves set bits", v, 32'h0F00_00F0);

        // R4 R5: all-plain 0x001 and all-clear 0x002
        bus_wr(10'h001, 32'h1357_9BDF);
        rd(10'h001, v);
        chk("R4 plain dword", v, 32'h1357_9BDF);
        hw_wr(10'h002, 32'hF0F0_FFFF);
        bus_wr(10'h002, 32'h00FF_00FF);
        rd(10'h002, v);
        chk("R5 clear dword", v, 32'hF000_FF00);

        // R3 R11: read-only and unmapped typed dwords
        bus_wr(10'h003, 32'hFFFF_FFFF);
        rd(10'h003, v);
        chk("R3 read-only default kept", v, 32'h1);
        bus_wr(10'h100, 32'hFFFF_FFFF);
        rd(10'h100, v);
        chk("R11 unmapped typed dword read-only", v, 32'h0);

        // R9: internal port overrides read-only bits
        hw_wr(10'h004, 32'hDEAD_BEEF);
        rd(10'h004, v);
        chk("R9 internal write to read-only dword", v, 32'hDEAD_BEEF);

        // R8: upper-half sweep
        for (int a = 10'h200; a < 10'h400; a += 10'h11) bus_wr(10'(a), upper_pat(a));
        for (int a = 10'h200; a < 10'h400; a += 10'h11) begin
            rd(10'(a), v);
            chk("R8 upper half readback", v, upper_pat(a));
        end

        // R7: write presented during busy is dropped
        bus_addr = 10'h001; bus_wdata = 32'h0000_1234; bus_we = 1'b1;
        tick();
        chk("R7 busy during pending write", {31'b0, bus_busy}, 32'd1);
        bus_addr = 10'h3F0; bus_wdata = 32'h0000_0077;
        tick();
        bus_we = 1'b0;
        rd(10'h3F0, v);
        chk("R7 write during busy dropped", v, 32'h0);
        rd(10'h001, v);
        chk("R7 accepted typed write stored", v, 32'h0000_1234);

        // R10: same-address collisions
        bus_addr = 10'h210; bus_wdata = 32'h1111_1111; bus_we = 1'b1;
        hw_addr = 10'h210; hw_wdata = 32'h2222_2222; hw_we = 1'b1;
        tick();
        bus_we = 1'b0; hw_we = 1'b0;
        rd(10'h210, v);
        chk("R10 internal wins on upper write", v, 32'h2222_2222);
        bus_addr = 10'h001; bus_wdata = 32'h0000_AAAA; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        hw_addr = 10'h001; hw_wdata = 32'h0000_5555; hw_we = 1'b1;
        tick();
        hw_we = 1'b0;
        rd(10'h001, v);
        chk("R10 internal wins on typed second cycle", v, 32'h0000_5555);

        // R1: reset again restores defaults
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        rd(10'h004, v);
        chk("R1 reset reloads default", v, 32'h0001_0301);
        rd(10'h210, v);
        chk("R1 reset clears upper", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule